// File: doc/BRIEF.md
# Two-word instruction sequencer

This block sits in the decode stage of a small processor with 16-bit program words. Four instructions take two words: a memory-to-memory move, a call, a goto and a load-pointer. The block watches each fetched word, together with a skip request from the conditional-test logic, and decides whether the word opens a two-word instruction, closes one, or stands alone. It issues one decoded operation with a 12-bit source operand and a 12-bit destination operand, one cycle after the word that completes it.

Every second word begins with the nibble 1111, which decodes as a harmless no-operation. A skip-if-zero test that skips a two-word instruction advances past only one word. The orphaned second word is still fetched, and the block issues it as a flagged NOP, so nothing is written. While the block is waiting for a second word, it consumes the next accepted word as the operand, whatever that word holds.

Top module: `dws_top`

## Requirements
- R1: After reset, issue_o, nop_o, src_o and dst_o are 0, op_o is NOP (0), and no second word is pending.
- R2: A word 1100 ssss_ssss_ssss starts a move. It produces no issue. The next accepted word completes the move: one cycle after that word, issue_o=1, op_o=MOVE (1), src_o is the first word's low 12 bits and dst_o is the second word's low 12 bits.
- R3: The first-word patterns 1110_110x (call, op 2), 1110_1110 (load-pointer, op 4) and 1110_1111 (goto, op 3) are also two-word instructions. For these, src_o is the first word's low 8 bits, zero-extended, and dst_o is the second word's low 12 bits.
- R4: The word that follows a two-word first word is always consumed as its operand, whatever its top 4 bits are. After that word, the pending state clears.
- R5: If skip_i is high with an accepted word and no second word is pending, that word is squashed. One cycle later issue_o=1, op_o=NOP, nop_o=0, and nothing becomes pending.
- R6: An accepted word whose top 4 bits are 1111 while nothing is pending is an orphaned second word. It issues op_o=NOP with nop_o=1.
- R7: A word 0110_011a ffff_ffff is the skip-if-zero test. It issues op_o=TSTZ (5), with src_o = {000, a, ffff_ffff} and dst_o=0.
- R8: Any other word issues op_o=OTHER (6), with src_o set to its low 12 bits and dst_o=0.
- R9: While a second word is pending, skip_i has no effect: the word completes the instruction.
- R10: A cycle with word_valid_i low gives issue_o=0 in the next cycle and leaves the pending state unchanged.
- R11: A skipped move followed by its second word issues no MOVE; only two NOP issues appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_valid_i | input | 1 | A fetched word is presented this cycle |
| word_i | input | 16 | Fetched program word |
| skip_i | input | 1 | Conditional-test logic requests that this word be skipped |
| issue_o | output | 1 | A decoded operation is issued this cycle |
| op_o | output | 3 | Operation: 0 NOP, 1 MOVE, 2 CALL, 3 GOTO, 4 LDPTR, 5 TSTZ, 6 OTHER |
| src_o | output | 12 | Source or first operand |
| dst_o | output | 12 | Destination or second operand |
| nop_o | output | 1 | The issue is an orphaned second word |

## Verification
On every cycle, the assertions check the pending-state protocol. A two-word first word sets the pending state and issues nothing. The next accepted word always clears the pending state. Skipped words and idle cycles produce their fixed issue pattern, and an orphan flag never appears without a NOP issue. Operand routing can only be shown by the bench scenarios against the reference model: which word's bits land in src_o and dst_o, the test-then-skipped-move sequence in which the move turns into two NOPs, and a long random word stream.

// File: rtl/dws_pkg.sv
package dws_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_MOVE  = 3'd1,
    OP_CALL  = 3'd2,
    OP_GOTO  = 3'd3,
    OP_LDPTR = 3'd4,
    OP_TSTZ  = 3'd5,
    OP_OTHER = 3'd6
  } op_e;

  localparam logic [3:0] TAIL_TAG = 4'b1111;
endpackage

// File: rtl/dws_classify.sv
module dws_classify import dws_pkg::*; #(
  parameter int WORD_W = 16,
  localparam int OPND_W = WORD_W - 4
) (
  input  logic [WORD_W-1:0] word_i,
  output op_e               op_o,
  output logic              lead_o,
  output logic              tail_o,
  output logic [OPND_W-1:0] src_o
);
  logic [7:0] hi8;
  assign hi8 = word_i[WORD_W-1 -: 8];

  always_comb begin
    op_o   = OP_OTHER;
    lead_o = 1'b0;
    tail_o = 1'b0;
    src_o  = word_i[OPND_W-1:0];
    if (hi8[7:4] == 4'b1100) begin
      op_o   = OP_MOVE;
      lead_o = 1'b1;
    end else if (hi8[7:1] == 7'b1110110) begin
      op_o   = OP_CALL;
      lead_o = 1'b1;
      src_o  = OPND_W'(word_i[7:0]);
    end else if (hi8 == 8'b1110_1110) begin
      op_o   = OP_LDPTR;
      lead_o = 1'b1;
      src_o  = OPND_W'(word_i[7:0]);
    end else if (hi8 == 8'b1110_1111) begin
      op_o   = OP_GOTO;
      lead_o = 1'b1;
      src_o  = OPND_W'(word_i[7:0]);
    end else if (hi8[7:4] == TAIL_TAG) begin
      op_o   = OP_NOP;
      tail_o = 1'b1;
      src_o  = '0;
    end else if (hi8[7:1] == 7'b0110011) begin
      op_o  = OP_TSTZ;
      src_o = OPND_W'(word_i[8:0]);
    end
  end
endmodule

// File: rtl/dws_pair.sv
module dws_pair import dws_pkg::*; #(
  parameter int WORD_W = 16,
  localparam int OPND_W = WORD_W - 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              skip_i,
  input  op_e               cls_op_i,
  input  logic              cls_lead_i,
  input  logic              cls_tail_i,
  input  logic [OPND_W-1:0] cls_src_i,
  input  logic [OPND_W-1:0] word_lo_i,
  output logic              pend_o,
  output logic              fire_o,
  output op_e               op_o,
  output logic [OPND_W-1:0] src_o,
  output logic [OPND_W-1:0] dst_o,
  output logic              orphan_o
);
  logic              pend_q, pend_d;
  op_e               lop_q, lop_d;
  logic [OPND_W-1:0] lsrc_q, lsrc_d;

  always_comb begin
    pend_d   = pend_q;
    lop_d    = lop_q;
    lsrc_d   = lsrc_q;
    fire_o   = 1'b0;
    op_o     = OP_NOP;
    src_o    = '0;
    dst_o    = '0;
    orphan_o = 1'b0;
    if (valid_i) begin
      if (pend_q) begin
        // operand word, consumed whatever its tag
        fire_o = 1'b1;
        op_o   = lop_q;
        src_o  = lsrc_q;
        dst_o  = word_lo_i;
        pend_d = 1'b0;
      end else if (skip_i) begin
        fire_o = 1'b1;
      end else if (cls_lead_i) begin
        pend_d = 1'b1;
        lop_d  = cls_op_i;
        lsrc_d = cls_src_i;
      end else begin
        fire_o   = 1'b1;
        op_o     = cls_op_i;
        src_o    = cls_src_i;
        orphan_o = cls_tail_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lop_q  <= OP_NOP;
      lsrc_q <= '0;
    end else begin
      pend_q <= pend_d;
      lop_q  <= lop_d;
      lsrc_q <= lsrc_d;
    end
  end

  assign pend_o = pend_q;

  a_r4_pend_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && valid_i |=> !pend_q);
  a_r2_lead_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q && valid_i && !skip_i && cls_lead_i |=> pend_q);
  a_r10_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pend_q));
endmodule

// File: rtl/dws_issue_reg.sv
module dws_issue_reg import dws_pkg::*; #(
  parameter int OPND_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  op_e               op_i,
  input  logic [OPND_W-1:0] src_i,
  input  logic [OPND_W-1:0] dst_i,
  input  logic              orphan_i,
  output logic              issue_o,
  output op_e               op_o,
  output logic [OPND_W-1:0] src_o,
  output logic [OPND_W-1:0] dst_o,
  output logic              nop_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_o <= 1'b0;
      op_o    <= OP_NOP;
      src_o   <= '0;
      dst_o   <= '0;
      nop_o   <= 1'b0;
    end else begin
      issue_o <= fire_i;
      nop_o   <= fire_i & orphan_i;
      if (fire_i) begin
        op_o  <= op_i;
        src_o <= src_i;
        dst_o <= dst_i;
      end
    end
  end

  a_r6_orphan_is_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_o |-> issue_o && op_o == OP_NOP);
endmodule

// File: rtl/dws_top.sv
module dws_top import dws_pkg::*; #(
  parameter int WORD_W = 16,
  localparam int OPND_W = WORD_W - 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              skip_i,
  output logic              issue_o,
  output logic [2:0]        op_o,
  output logic [OPND_W-1:0] src_o,
  output logic [OPND_W-1:0] dst_o,
  output logic              nop_o
);
  op_e               cls_op, pr_op, iss_op;
  logic              cls_lead, cls_tail, pend, fire, orphan;
  logic [OPND_W-1:0] cls_src, pr_src, pr_dst;

  dws_classify #(.WORD_W(WORD_W)) u_cls (
    .word_i (word_i),
    .op_o   (cls_op),
    .lead_o (cls_lead),
    .tail_o (cls_tail),
    .src_o  (cls_src)
  );

  dws_pair #(.WORD_W(WORD_W)) u_pair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (word_valid_i),
    .skip_i     (skip_i),
    .cls_op_i   (cls_op),
    .cls_lead_i (cls_lead),
    .cls_tail_i (cls_tail),
    .cls_src_i  (cls_src),
    .word_lo_i  (word_i[OPND_W-1:0]),
    .pend_o     (pend),
    .fire_o     (fire),
    .op_o       (pr_op),
    .src_o      (pr_src),
    .dst_o      (pr_dst),
    .orphan_o   (orphan)
  );

  dws_issue_reg #(.OPND_W(OPND_W)) u_iss (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .op_i     (pr_op),
    .src_i    (pr_src),
    .dst_i    (pr_dst),
    .orphan_i (orphan),
    .issue_o  (issue_o),
    .op_o     (iss_op),
    .src_o    (src_o),
    .dst_o    (dst_o),
    .nop_o    (nop_o)
  );

  assign op_o = iss_op;

  a_r2_lead_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i && !pend && !skip_i && cls_lead |=> !issue_o);
  a_r5_skip_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i && !pend && skip_i |=> issue_o && op_o == 3'd0 && !nop_o && !pend);
  a_r9_skip_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i && pend && skip_i |=> issue_o && !nop_o);
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_i |=> !issue_o);
endmodule

// File: tb/tb_dws_top.sv
module tb_dws_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wv = 1'b0;
  logic [15:0] w = '0;
  logic        sk = 1'b0;
  logic        issue, nop;
  logic [2:0]  op;
  logic [11:0] src, dst;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int m_pend = 0;
  int m_lop = 0;
  int m_lsrc = 0;
  int e_issue, e_op, e_src, e_dst, e_nop;

  always #2 clk = ~clk;

  dws_top dut (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(wv), .word_i(w), .skip_i(sk),
    .issue_o(issue), .op_o(op), .src_o(src), .dst_o(dst), .nop_o(nop)
  );

  task automatic check(input string req, input int got, input int exp, input string what);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic model(input bit v, input int word, input bit s);
    int hi4, hi8, hi7;
    hi4 = (word >> 12) & 15;
    hi8 = (word >> 8) & 255;
    hi7 = (word >> 9) & 127;
    e_issue = 0; e_nop = 0; e_op = 0; e_src = 0; e_dst = 0;
    if (!v) return;
    if (m_pend != 0) begin
      e_issue = 1; e_op = m_lop; e_src = m_lsrc; e_dst = word & 12'hFFF;
      m_pend = 0;
    end else if (s) begin
      e_issue = 1;
    end else if (hi4 == 12) begin
      m_pend = 1; m_lop = 1; m_lsrc = word & 12'hFFF;
    end else if (hi8 == 8'hEC || hi8 == 8'hED) begin
      m_pend = 1; m_lop = 2; m_lsrc = word & 8'hFF;
    end else if (hi8 == 8'hEE) begin
      m_pend = 1; m_lop = 4; m_lsrc = word & 8'hFF;
    end else if (hi8 == 8'hEF) begin
      m_pend = 1; m_lop = 3; m_lsrc = word & 8'hFF;
    end else if (hi4 == 15) begin
      e_issue = 1; e_nop = 1;
    end else if (hi7 == 7'b0110011) begin
      e_issue = 1; e_op = 5; e_src = word & 9'h1FF;
    end else begin
      e_issue = 1; e_op = 6; e_src = word & 12'hFFF;
    end
  endtask

  task automatic step(input string req, input bit v, input int word, input bit s);
    wv = v; w = word[15:0]; sk = s;
    model(v, word, s);
    @(negedge clk);
    check(req, int'(issue), e_issue, "issue");
    check(req, int'(nop), e_nop, "nop");
    if (e_issue != 0) begin
      check(req, int'(op), e_op, "op");
      check(req, int'(src), e_src, "src");
      check(req, int'(dst), e_dst, "dst");
    end
  endtask

  initial begin
    int moves;
    @(negedge clk);
    check("R1", int'(issue), 0, "issue");
    check("R1", int'(op), 0, "op");
    check("R1", int'(src) + int'(dst) + int'(nop), 0, "fields");
    rst_n = 1'b1;
    @(negedge clk);
    // R2 move, test nonzero -> move executes
    step("R7", 1, 16'h6612, 0);
    step("R2", 1, 16'hC123, 0);
    step("R2", 1, 16'hF456, 0);
    // R11 test zero -> skipped move, orphan tail
    moves = 0;
    step("R7", 1, 16'h6734, 0);
    step("R11", 1, 16'hC123, 1);
    if (op == 3'd1) moves++;
    step("R11", 1, 16'hF456, 0);
    if (op == 3'd1) moves++;
    check("R11", moves, 0, "move count");
    // R3 call, goto, ldptr
    step("R3", 1, 16'hED5A, 0);
    step("R3", 1, 16'hF9AB, 0);
    step("R3", 1, 16'hEF77, 0);
    step("R3", 1, 16'hF001, 0);
    step("R3", 1, 16'hEE3C, 0);
    step("R3", 1, 16'hFFFF, 0);
    // R4 non-tail operand word still consumed
    step("R4", 1, 16'hC0AA, 0);
    step("R4", 1, 16'h1234, 0);
    step("R4", 1, 16'h1234, 0);
    // R9 skip ignored while pending, R10 idle gap
    step("R9", 1, 16'hC0BB, 0);
    step("R10", 0, 16'hFFFF, 1);
    step("R10", 0, 16'h0000, 0);
    step("R9", 1, 16'hF0CC, 1);
    // R6 orphan, R5 skip of single word, R8 other
    step("R6", 1, 16'hF777, 0);
    step("R5", 1, 16'h0ABC, 1);
    step("R8", 1, 16'h0ABC, 0);
    step("R8", 1, 16'h6400, 0);
    // random stream
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom);
      step("R8", (r & 7) != 0, (r >> 8) & 16'hFFFF, ((r >> 4) & 3) == 0);
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule